// File: doc/BRIEF.md
# Store-Multiple Write Burst Generator

This block turns a short store of one, two or three consecutive 32-bit words into AXI write transactions on a 64-bit data bus. The target region is write-through or noncacheable. The requester presents a word-aligned start address, a word count and up to three data words. The block derives the size, length and first strobe of each burst from the word offset inside a 32-byte line. It then issues the address phase, the data beats with byte strobes and WLAST, and counts the write responses.

A request that would run past the end of its 32-byte line becomes two transactions. The second one restarts at byte offset zero of the same line and carries the remaining words. The requester sees one handshake to accept the request and one completion pulse. The pulse comes only after every write response for that request has returned.

Top module: `smw_burst_gen`

## Requirements
- R1: A two-word store whose start word index (address bits 4:2) is even and below 7 becomes one transaction with AWSIZE=3 (8 bytes) and AWLEN=0. Its single beat has WSTRB=0xFF and WDATA = {second word, first word}.
- R2: A two-word store at word index 1, 3 or 5 becomes one transaction with AWSIZE=2 (4 bytes) and AWLEN=1. The first beat has WSTRB=0xF0 and the second beat has WSTRB=0x0F.
- R3: A three-word store at word index 0 to 5 becomes one transaction with AWSIZE=2 and AWLEN=2. The beat strobes alternate, starting with 0x0F at an even index and with 0xF0 at an odd index.
- R4: A single-word store (count 1) becomes one 32-bit beat (AWSIZE=2, AWLEN=0), with WSTRB=0x0F at an even word index and 0xF0 at an odd one.
- R5: A store that crosses the line end is split into two transactions:
  - two words at index 7 become one word at 0x1C, then one word at 0x00;
  - three words at index 6 become two words at 0x18 (one 64-bit beat), then one word at 0x00;
  - three words at index 7 become one word at 0x1C, then two words at 0x00 (one 64-bit beat).
- R6: AWADDR of each transaction is its start address, and the second half of a split uses the line base address. AWBURST is always INCR (2'b01).
- R7: Each 32-bit word sits on the lanes selected by bit 2 of its byte address: upper lanes [63:32] when the bit is 1, lower lanes [31:0] when it is 0. Unstrobed lanes carry zero. WLAST is high on the final beat of each transaction only.
- R8: AWVALID of the second transaction of a split does not rise until the first transaction's address handshake and all of its data handshakes have completed.
- R9: REQ_READY is high only while idle, and a request is taken when REQ_VALID and REQ_READY are both high. REQ_DONE pulses for one cycle only after all write responses of the request (one or two) have been received. BREADY is high only while a request is in progress.
- R10: Once AWVALID or WVALID is high without its ready, it stays high with an unchanged payload until the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Store request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Word-aligned start byte address |
| req_count | input | 2 | Number of words, 1 to 3 |
| req_data | input | 96 | Words: first in [31:0], second in [63:32], third in [95:64] |
| req_done | output | 1 | One-cycle pulse when all responses have returned |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | 32 | Transaction start address |
| awburst | output | 2 | Burst type, always INCR |
| awsize | output | 3 | Beat size code (2 = 4 bytes, 3 = 8 bytes) |
| awlen | output | 8 | Beats minus one |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | 64 | Write data |
| wstrb | output | 8 | Byte strobes |
| wlast | output | 1 | Final beat of the transaction |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |

## Verification
The assertions check on every cycle the properties that hold whatever the request:
- AWBURST stays INCR.
- An 8-byte burst has one beat at an even word, and a 4-byte burst never runs past the line end.
- Stalled address and data phases hold their payload.
- The ready and response-ready signals follow the request lifetime.

The bench's scenarios cover every start offset and count under random back-pressure. They show:
- the exact split points and the restart address;
- the strobe sequence and lane placement of each beat;
- the order of the two transactions of a split;
- that completion waits for both responses.

// File: rtl/smw_pkg.sv
package smw_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int BUS_W      = 2 * WORD_W;
    localparam int LINE_BYTES = 32;
    localparam int MAX_WORDS  = 3;
    localparam int CNT_W      = 2;
    localparam int LEN_W      = 8;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int WIDX_W     = OFF_W - 2;
    localparam int LINE_WORDS = LINE_BYTES / 4;
    localparam int STRB_W     = BUS_W / 8;
    localparam int LANE_W     = WORD_W / 8;
    localparam int DATA_W     = MAX_WORDS * WORD_W;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [2:0] SIZE_32    = 3'd2;
    localparam logic [2:0] SIZE_64    = 3'd3;

    // One transaction: start address, words carried, first request word used
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  words;
        logic [CNT_W-1:0]  base;
    } seg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_SEG, ST_RESP} state_t;

    function automatic logic seg_is_wide(seg_t s);
        return (s.words == CNT_W'(2)) && !s.addr[2];
    endfunction

    function automatic logic [LEN_W-1:0] seg_len(seg_t s);
        return seg_is_wide(s) ? '0 : (LEN_W'(s.words) - LEN_W'(1));
    endfunction

    function automatic logic [STRB_W-1:0] lane_strb(logic upper);
        return upper ? {{LANE_W{1'b1}}, {LANE_W{1'b0}}}
                     : {{LANE_W{1'b0}}, {LANE_W{1'b1}}};
    endfunction
endpackage

// File: rtl/smw_splitter.sv
module smw_splitter
    import smw_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    output seg_t              seg0,
    output seg_t              seg1,
    output logic              two_segs
);
    localparam int RW = WIDX_W + 1;

    logic [WIDX_W-1:0] widx;
    logic [RW-1:0]     room;
    logic [RW-1:0]     need;
    logic [CNT_W-1:0]  first_n;

    always_comb begin
        widx    = addr[OFF_W-1:2];
        room    = RW'(LINE_WORDS) - RW'(widx);
        need    = RW'(count);
        first_n = (need > room) ? CNT_W'(room) : count;

        seg0.addr  = addr;
        seg0.words = first_n;
        seg0.base  = '0;

        seg1.addr  = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        seg1.words = count - first_n;
        seg1.base  = first_n;

        two_segs   = count > first_n;
    end
endmodule

// File: rtl/smw_beat_mux.sv
module smw_beat_mux
    import smw_pkg::*;
(
    input  seg_t              seg,
    input  logic [CNT_W-1:0]  beat,
    input  logic [DATA_W-1:0] data,
    output logic [ADDR_W-1:0] awaddr,
    output logic [2:0]        awsize,
    output logic [LEN_W-1:0]  awlen,
    output logic [BUS_W-1:0]  wdata,
    output logic [STRB_W-1:0] wstrb,
    output logic              wlast
);
    localparam int SLOTS = 1 << CNT_W;

    logic [WORD_W-1:0] words [SLOTS];

    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_slot
            if (i < MAX_WORDS) begin : g_used
                assign words[i] = data[i*WORD_W +: WORD_W];
            end else begin : g_pad
                assign words[i] = '0;
            end
        end
    endgenerate

    logic             wide;
    logic [CNT_W-1:0] idx;
    logic             upper;

    always_comb begin
        wide   = seg_is_wide(seg);
        awaddr = seg.addr;
        awsize = wide ? SIZE_64 : SIZE_32;
        awlen  = seg_len(seg);
        idx    = seg.base + beat;
        upper  = seg.addr[2] ^ beat[0];
        if (wide) begin
            wdata = {words[idx + CNT_W'(1)], words[idx]};
            wstrb = '1;
        end else begin
            wdata = upper ? {words[idx], {WORD_W{1'b0}}}
                          : {{WORD_W{1'b0}}, words[idx]};
            wstrb = lane_strb(upper);
        end
        wlast = LEN_W'(beat) == awlen;
    end
endmodule

// File: rtl/smw_ctrl.sv
module smw_ctrl
    import smw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_data,
    input  seg_t              seg0_in,
    input  seg_t              seg1_in,
    input  logic              two_in,
    input  logic              wlast,
    input  logic              awready,
    input  logic              wready,
    input  logic              bvalid,
    output logic              req_ready,
    output logic              req_done,
    output logic              awvalid,
    output logic              wvalid,
    output logic              bready,
    output seg_t              cur_seg,
    output logic [CNT_W-1:0]  beat,
    output logic [DATA_W-1:0] data_q
);
    state_t     st;
    seg_t       seg0_q, seg1_q;
    logic       two_q, sel;
    logic       aw_pend, w_pend;
    logic [1:0] bcnt;
    logic [1:0] bcnt_nx;
    logic [1:0] nseg;
    logic       aw_hs, w_hs, b_hs, aw_fin, w_fin;

    always_comb begin
        req_ready = st == ST_IDLE;
        awvalid   = (st == ST_SEG) && aw_pend;
        wvalid    = (st == ST_SEG) && w_pend;
        bready    = st != ST_IDLE;
        cur_seg   = sel ? seg1_q : seg0_q;
        aw_hs     = awvalid && awready;
        w_hs      = wvalid && wready;
        b_hs      = bvalid && bready;
        aw_fin    = !aw_pend || aw_hs;
        w_fin     = !w_pend || (w_hs && wlast);
        nseg      = two_q ? 2'd2 : 2'd1;
        bcnt_nx   = bcnt + {1'b0, b_hs};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            seg0_q   <= '0;
            seg1_q   <= '0;
            two_q    <= 1'b0;
            sel      <= 1'b0;
            aw_pend  <= 1'b0;
            w_pend   <= 1'b0;
            beat     <= '0;
            bcnt     <= '0;
            data_q   <= '0;
            req_done <= 1'b0;
        end else begin
            req_done <= 1'b0;
            bcnt     <= bcnt_nx;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        seg0_q  <= seg0_in;
                        seg1_q  <= seg1_in;
                        two_q   <= two_in;
                        data_q  <= req_data;
                        sel     <= 1'b0;
                        aw_pend <= 1'b1;
                        w_pend  <= 1'b1;
                        beat    <= '0;
                        bcnt    <= '0;
                        st      <= ST_SEG;
                    end
                end
                ST_SEG: begin
                    if (aw_hs) aw_pend <= 1'b0;
                    if (w_hs) begin
                        if (wlast) w_pend <= 1'b0;
                        else       beat   <= beat + CNT_W'(1);
                    end
                    if (aw_fin && w_fin) begin
                        if (!sel && two_q) begin
                            sel     <= 1'b1;
                            aw_pend <= 1'b1;
                            w_pend  <= 1'b1;
                            beat    <= '0;
                        end else begin
                            st <= ST_RESP;
                        end
                    end
                end
                ST_RESP: begin
                    if (bcnt_nx == nseg) begin
                        req_done <= 1'b1;
                        st       <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/smw_burst_gen.sv
module smw_burst_gen
    import smw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_done,
    output logic              awvalid,
    input  logic              awready,
    output logic [ADDR_W-1:0] awaddr,
    output logic [1:0]        awburst,
    output logic [2:0]        awsize,
    output logic [LEN_W-1:0]  awlen,
    output logic              wvalid,
    input  logic              wready,
    output logic [BUS_W-1:0]  wdata,
    output logic [STRB_W-1:0] wstrb,
    output logic              wlast,
    input  logic              bvalid,
    output logic              bready
);
    seg_t              seg0, seg1, cur_seg;
    logic              two_segs;
    logic [CNT_W-1:0]  beat;
    logic [DATA_W-1:0] data_q;

    assign awburst = BURST_INCR;

    smw_splitter u_split (
        .addr     (req_addr),
        .count    (req_count),
        .seg0     (seg0),
        .seg1     (seg1),
        .two_segs (two_segs)
    );

    smw_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_data  (req_data),
        .seg0_in   (seg0),
        .seg1_in   (seg1),
        .two_in    (two_segs),
        .wlast     (wlast),
        .awready   (awready),
        .wready    (wready),
        .bvalid    (bvalid),
        .req_ready (req_ready),
        .req_done  (req_done),
        .awvalid   (awvalid),
        .wvalid    (wvalid),
        .bready    (bready),
        .cur_seg   (cur_seg),
        .beat      (beat),
        .data_q    (data_q)
    );

    smw_beat_mux u_mux (
        .seg    (cur_seg),
        .beat   (beat),
        .data   (data_q),
        .awaddr (awaddr),
        .awsize (awsize),
        .awlen  (awlen),
        .wdata  (wdata),
        .wstrb  (wstrb),
        .wlast  (wlast)
    );
endmodule

// File: rtl/smw_checker.sv
module smw_checker
    import smw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_done,
    input logic              awvalid,
    input logic              awready,
    input logic [ADDR_W-1:0] awaddr,
    input logic [1:0]        awburst,
    input logic [2:0]        awsize,
    input logic [LEN_W-1:0]  awlen,
    input logic              wvalid,
    input logic              wready,
    input logic [STRB_W-1:0] wstrb,
    input logic              wlast
);
    localparam int RW = WIDX_W + 1;

    assert_burst_incr_R6: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> awburst == BURST_INCR);

    assert_wide_even_single_R1: assert property (@(posedge clk) disable iff (rst)
        (awvalid && awsize == SIZE_64) |-> (awlen == '0 && !awaddr[2]));

    assert_narrow_in_line_R5: assert property (@(posedge clk) disable iff (rst)
        (awvalid && awsize == SIZE_32) |->
        (RW'(awaddr[OFF_W-1:2]) + RW'(awlen)) < RW'(LINE_WORDS));

    assert_narrow_half_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (wvalid && awsize == SIZE_32) |-> $countones(wstrb) == LANE_W);

    assert_wide_full_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (wvalid && awsize == SIZE_64) |-> (wstrb == '1 && wlast));

    assert_aw_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlen)));

    assert_w_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (wvalid && !wready) |=> (wvalid && $stable(wstrb) && $stable(wlast)));

    assert_take_then_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        req_done |-> req_ready);
endmodule

bind smw_burst_gen smw_checker u_chk (.*);

// File: tb/tb_smw_burst_gen.sv
module tb_smw_burst_gen;
    import smw_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic [CNT_W-1:0]  req_count;
    logic [DATA_W-1:0] req_data;
    logic              req_done;
    logic              awvalid, awready;
    logic [ADDR_W-1:0] awaddr;
    logic [1:0]        awburst;
    logic [2:0]        awsize;
    logic [LEN_W-1:0]  awlen;
    logic              wvalid, wready;
    logic [BUS_W-1:0]  wdata;
    logic [STRB_W-1:0] wstrb;
    logic              wlast;
    logic              bvalid, bready;

    always #5 clk = ~clk;

    smw_burst_gen dut (.*);

    typedef struct {
        logic [31:0] addr;
        logic [2:0]  size;
        logic [7:0]  len;
        string       tag;
    } aw_exp_t;

    typedef struct {
        logic [63:0] data;
        logic [7:0]  strb;
        logic        last;
        string       tag;
    } w_exp_t;

    aw_exp_t aw_q[$];
    w_exp_t  w_q[$];

    int   n_chk = 0;
    int   n_fail = 0;
    int   b_pend = 0;
    int   aw_seen = 0;
    int   wl_seen = 0;
    bit   split_now = 0;
    bit   r8_checked = 0;
    bit   force_rdy = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected beats of one transaction, built from the requirements
    task automatic push_txn(input logic [31:0] a, input int k, input int start,
                            input logic [95:0] d, input string tag);
        aw_exp_t ae;
        w_exp_t  we;
        ae.addr = a;
        ae.tag  = tag;
        if (k == 2 && !a[2]) begin
            ae.size = 3'd3; ae.len = 8'd0;
            aw_q.push_back(ae);
            we.data = {d[(start+1)*32 +: 32], d[start*32 +: 32]};
            we.strb = 8'hFF; we.last = 1'b1; we.tag = tag;
            w_q.push_back(we);
        end else begin
            ae.size = 3'd2; ae.len = 8'(k - 1);
            aw_q.push_back(ae);
            for (int j = 0; j < k; j++) begin
                bit up;
                up = a[2] ^ j[0];
                we.data = up ? {d[(start+j)*32 +: 32], 32'h0} : {32'h0, d[(start+j)*32 +: 32]};
                we.strb = up ? 8'hF0 : 8'h0F;
                we.last = (j == k - 1);
                we.tag  = tag;
                w_q.push_back(we);
            end
        end
    endtask

    task automatic run_req(input logic [31:0] addr, input int cnt, input logic [95:0] d);
        int    w, first;
        string tag;
        bit    got;
        w     = int'(addr[4:2]);
        first = (w + cnt > 8) ? 8 - w : cnt;
        if (cnt == 1)            tag = "R4";
        else if (first < cnt)    tag = "R5";
        else if (cnt == 2)       tag = (w % 2 == 0) ? "R1" : "R2";
        else                     tag = "R3";
        push_txn(addr, first, 0, d, tag);
        if (cnt > first) push_txn({addr[31:5], 5'd0}, cnt - first, first, d, tag);
        split_now  = cnt > first;
        r8_checked = 0;
        aw_seen    = 0;
        wl_seen    = 0;

        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = addr; req_count = 2'(cnt); req_data = d;
        @(negedge clk); #1;
        check(req_ready == 1'b1, "R9", "ready while idle", 64'(req_ready), 64'd1);
        @(posedge clk); #1;
        req_valid = 1'b0;
        got = 0;
        for (int i = 0; i < 2000 && !got; i++) begin
            @(negedge clk); #1;
            if (req_done) got = 1;
        end
        check(got, "R9", "completion pulse seen", 64'(got), 64'd1);
        check(aw_q.size() == 0 && w_q.size() == 0, "R9", "all beats sent before done",
              64'(aw_q.size() + w_q.size()), 64'd0);
        check(b_pend == 0, "R9", "all responses before done", 64'(b_pend), 64'd0);
        if (split_now)
            check(r8_checked, "R8", "second address phase observed", 64'(r8_checked), 64'd1);
        @(negedge clk); #1;
        check(!req_done, "R9", "done lasts one cycle", 64'(req_done), 64'd0);
    endtask

    // Ready / response generator: drives just after the rising edge
    always begin
        @(posedge clk); #1;
        lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        awready = force_rdy | lfsr[0] | lfsr[3];
        wready  = force_rdy | lfsr[1] | lfsr[5];
        bvalid  = (b_pend > 0) && (force_rdy | lfsr[2]);
    end

    // Monitor: compares handshakes with the expected queues
    logic              aw_stall_q = 0, w_stall_q = 0;
    logic [ADDR_W-1:0] awaddr_q;
    logic [BUS_W-1:0]  wdata_q;
    always @(negedge clk) begin
        aw_exp_t ae;
        w_exp_t  we;
        if (!rst) begin
            if (aw_stall_q)
                check(awvalid && awaddr == awaddr_q, "R10", "address held while stalled",
                      64'(awaddr), 64'(awaddr_q));
            if (w_stall_q)
                check(wvalid && wdata == wdata_q, "R10", "data held while stalled",
                      wdata, wdata_q);
            if (split_now && awvalid && aw_seen == 1 && !r8_checked) begin
                r8_checked = 1;
                check(wl_seen == 1, "R8", "first data done before second address",
                      64'(wl_seen), 64'd1);
            end
            if (awvalid && awready) begin
                if (aw_q.size() == 0) begin
                    check(0, "R6", "unexpected address phase", 64'(awaddr), 64'd0);
                end else begin
                    ae = aw_q.pop_front();
                    check(awaddr == ae.addr, {ae.tag, " R6"}, "awaddr", 64'(awaddr), 64'(ae.addr));
                    check(awburst == 2'b01, {ae.tag, " R6"}, "awburst", 64'(awburst), 64'd1);
                    check(awsize == ae.size, ae.tag, "awsize", 64'(awsize), 64'(ae.size));
                    check(awlen == ae.len, ae.tag, "awlen", 64'(awlen), 64'(ae.len));
                end
                aw_seen++;
            end
            if (wvalid && wready) begin
                if (w_q.size() == 0) begin
                    check(0, "R7", "unexpected data beat", wdata, 64'd0);
                end else begin
                    we = w_q.pop_front();
                    check(wstrb == we.strb, we.tag, "wstrb", 64'(wstrb), 64'(we.strb));
                    check(wdata == we.data, {we.tag, " R7"}, "wdata", wdata, we.data);
                    check(wlast == we.last, {we.tag, " R7"}, "wlast", 64'(wlast), 64'(we.last));
                end
                if (wlast) wl_seen++;
            end
            b_pend = b_pend + ((awvalid && awready) ? 1 : 0) - ((bvalid && bready) ? 1 : 0);
            aw_stall_q = awvalid && !awready;
            w_stall_q  = wvalid && !wready;
            awaddr_q   = awaddr;
            wdata_q    = wdata;
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_count = '0; req_data = '0;
        awready = 1'b0; wready = 1'b0; bvalid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        check(req_ready == 1'b1, "R9", "reset ready", 64'(req_ready), 64'd1);
        check(!awvalid && !wvalid, "R8", "no traffic after reset", 64'({awvalid, wvalid}), 64'd0);
        check(!req_done && !bready, "R9", "no done or bready after reset",
              64'({req_done, bready}), 64'd0);

        for (int pass = 0; pass < 2; pass++) begin
            force_rdy = (pass == 1);
            for (int c = 1; c <= 3; c++) begin
                for (int off = 0; off < 8; off++) begin
                    logic [31:0] a;
                    logic [95:0] d;
                    a = 32'h4000_0100 + 32'(pass * 4096 + c * 256 + off * 4);
                    d = {32'hC300_0000 + 32'(c * 16 + off),
                         32'hB200_0000 + 32'(c * 16 + off),
                         32'hA100_0000 + 32'(c * 16 + off)};
                    run_req(a, c, d);
                end
            end
        end

        repeat (5) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule